// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad that serves a group of parallel lanes. Its storage is split into equal banks, and each bank can complete one access per cycle independently of the others. A request presents, for every lane at once, a valid bit, a write enable, a 4-byte word address and write data. The block captures the whole group, finds the bank that each lane maps to, and serves it in one or more passes. Each pass takes one clock cycle. Lanes that land in different banks share a pass. Lanes that want different rows of the same bank are split across passes. Lanes that want the same row of a bank share that row's single access, so a read of it reaches all of them as a broadcast.

A mode bit captured with the request picks the bank row width. In 4-byte mode a row is one word. In 8-byte mode a row is an aligned pair of words, so two lanes that touch the two halves of one 64-bit value never conflict. `busy` is high while passes are running. `done` then pulses for one cycle, and at that point the read data of every lane is valid. The block ignores a new request while it is busy.

Top module: `banked_scratch`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A request whose valid lanes all map to distinct banks completes in exactly one pass, so `busy` is high for exactly one cycle.
- R3: In 4-byte mode the row key is the full word address and the bank is word address bits [4:0]. The number of passes equals the largest number of distinct row keys among the valid lanes of any one bank.
- R4: Valid lanes that read the same row of a bank are served in the same pass, and each of them returns the stored word.
- R5: In 8-byte mode the row key is word address bits [7:1] and the bank is word address bits [5:1]. The two words of an aligned pair therefore share a row and add no pass.
- R6: When several valid lanes of one request write the same word, the word keeps the data of the highest-numbered of those lanes.
- R7: A lane whose valid bit is low does not write storage and does not count toward the pass total. Its read data is zero when `done` pulses.
- R8: A request is accepted on a rising edge where `start` is high and `busy` is low. `busy` is high for one cycle per pass, starting the cycle after acceptance. `done` is high for exactly the one cycle after `busy` falls. A `start` while `busy` is high is ignored.
- R9: A request with no valid lanes takes one pass and returns all-zero read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| wide | input | 1 | Row width mode: 0 = 4-byte, 1 = 8-byte |
| lane_valid | input | LANES | Per-lane request valid |
| lane_we | input | LANES | Per-lane write enable (1 = write, 0 = read) |
| lane_addr | input | LANES*WAW | Per-lane 4-byte word address; lane i at bits [i*WAW +: WAW] |
| lane_wdata | input | LANES*DW | Per-lane write data; lane i at bits [i*DW +: DW] |
| busy | output | 1 | Passes in progress |
| done | output | 1 | One-cycle completion pulse |
| lane_rdata | output | LANES*DW | Per-lane read data; lane i at bits [i*DW +: DW] |

## Verification
The bench counts the busy cycles of every request and compares them with a reference model that counts distinct row keys per bank in both modes. It drives strides that put 1, 2, 4 and 8 rows into one bank. A scheduler that serialized every lane sharing a bank, or that failed to merge broadcast reads, would show an inflated count. A scheduler that merged different rows would show a short count, and it would also return wrong read data. Repeated writes to one word check which lane wins, and would catch a design that kept the lowest lane's data. Masked lanes, an empty request and a `start` pulse injected in the middle of a long request would catch stray writes, stale read data and a design that re-accepts while busy.

// File: rtl/banked_scratch.sv
module banked_scratch #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int WAW   = 8,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 wide,
  input  logic [LANES-1:0]     lane_valid,
  input  logic [LANES-1:0]     lane_we,
  input  logic [LANES*WAW-1:0] lane_addr,
  input  logic [LANES*DW-1:0]  lane_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [LANES*DW-1:0]  lane_rdata
);
  localparam int WORDS = 1 << WAW;
  localparam int BW    = $clog2(BANKS);

  logic [DW-1:0]    mem [WORDS];
  logic [WAW-1:0]   addr_q [LANES];
  logic [DW-1:0]    wd_q [LANES];
  logic [DW-1:0]    rd_q [LANES];
  logic [LANES-1:0] we_q, pend_q, served, left;
  logic             wide_q, busy_q, done_q;

  logic [WAW-1:0]   key  [LANES];
  logic [BW-1:0]    bank [LANES];
  logic [WAW-1:0]   lead [BANKS];

  wire accept = start && !busy_q;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      key[i]  = wide_q ? {1'b0, addr_q[i][WAW-1:1]} : addr_q[i];
      bank[i] = key[i][BW-1:0];
    end
    for (int b = 0; b < BANKS; b++) begin
      lead[b] = '0;
      for (int i = LANES - 1; i >= 0; i--)
        if (pend_q[i] && bank[i] == BW'(b)) lead[b] = key[i];
    end
    for (int i = 0; i < LANES; i++)
      served[i] = pend_q[i] && (key[i] == lead[bank[i]]);
    for (int i = 0; i < LANES; i++)
      lane_rdata[i*DW +: DW] = rd_q[i];
  end

  assign left = pend_q & ~served;
  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        pend_q <= lane_valid;
      end else if (busy_q) begin
        pend_q <= left;
        if (left == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      wide_q <= wide;
      we_q   <= lane_we;
      for (int i = 0; i < LANES; i++) begin
        addr_q[i] <= lane_addr[i*WAW +: WAW];
        wd_q[i]   <= lane_wdata[i*DW +: DW];
        rd_q[i]   <= '0;
      end
    end else if (busy_q) begin
      for (int i = 0; i < LANES; i++) begin
        if (served[i] && we_q[i])  mem[addr_q[i]] <= wd_q[i];
        if (served[i] && !we_q[i]) rd_q[i] <= mem[addr_q[i]];
      end
    end
  end
endmodule

// File: rtl/scratch_checks.sv
module scratch_checks #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [LANES-1:0] pend,
  input logic [LANES-1:0] served
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R8
  AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n) (busy && pend != '0) |-> served != '0); // R3
  AST_SERVE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (served & ~pend) == '0); // R7
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !$past(busy)) |-> pend == '0); // R7
endmodule

bind banked_scratch scratch_checks #(.LANES(LANES)) u_scratch_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pend(pend_q), .served(served)
);

// File: tb/test_banked_scratch.sv
module test_banked_scratch;
  localparam int L = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0;
  logic [L-1:0]   lane_valid = '0, lane_we = '0;
  logic [L*8-1:0] lane_addr = '0;
  logic [L*32-1:0] lane_wdata = '0, lane_rdata;
  logic busy, done;

  banked_scratch i_banked_scratch (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic        wd;
    logic [7:0]  mult;
    logic [7:0]  off;
    logic [31:0] mask;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd1,  8'd0, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 8'd0,  8'd5, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 8'd32, 8'd0, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 8'd2,  8'd0, 32'hFFFF_FFFF},
    '{1'b0, 1'b1, 8'd2,  8'd0, 32'hFFFF_FFFF},
    '{1'b0, 1'b1, 8'd1,  8'd0, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 8'd64, 8'd3, 32'hFFFF_FFFF},
    '{1'b1, 1'b0, 8'd33, 8'd0, 32'hFFFF_FFFF},
    '{1'b1, 1'b1, 8'd64, 8'd0, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 8'd1,  8'd0, 32'hFFFF_FFFF},
    '{1'b0, 1'b1, 8'd16, 8'd1, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 8'd32, 8'd0, 32'h0000_00FF},
    '{1'b1, 1'b0, 8'd1,  8'd64, 32'h0F0F_0F0F}
  };

  int nvec = 0, nbad = 0, seq = 0;
  logic [31:0] model [256];
  int wa [L];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model_passes(input bit wd, input logic [31:0] mask);
    int cnt [L];
    int mx = 0;
    for (int b = 0; b < L; b++) cnt[b] = 0;
    for (int i = 0; i < L; i++) begin
      int k;
      bit first;
      if (!mask[i]) continue;
      k = wd ? wa[i] >> 1 : wa[i];
      first = 1'b1;
      for (int j = 0; j < i; j++)
        if (mask[j] && (wd ? wa[j] >> 1 : wa[j]) == k) first = 1'b0;
      if (first) cnt[k % 32]++;
    end
    for (int b = 0; b < L; b++) if (cnt[b] > mx) mx = cnt[b];
    return (mx == 0) ? 1 : mx;
  endfunction

  function automatic logic [31:0] data_of(input int s, input int i);
    return 32'h5A00_0000 ^ (s << 12) ^ (i * 32'h0001_0203);
  endfunction

  task automatic run_req(input bit we, input bit wd, input int mult, input int off,
                         input logic [31:0] mask, input bit intrude, input string req);
    int cyc = 0, exp_p;
    bit rd_ok = 1'b1;
    logic [31:0] ra = 0, re = 0;
    seq++;
    for (int i = 0; i < L; i++) wa[i] = (i * mult + off) & 255;
    exp_p = model_passes(wd, mask);
    @(negedge clk);
    start = 1'b1; wide = wd; lane_valid = mask; lane_we = {L{we}};
    for (int i = 0; i < L; i++) begin
      lane_addr[i*8 +: 8]   = wa[i][7:0];
      lane_wdata[i*32 +: 32] = data_of(seq, i);
    end
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (busy) cyc++;
      if (intrude && cyc == 2) begin
        start = 1'b1; lane_valid = '1; lane_we = '1;
        lane_addr = '0; lane_wdata = {L{32'hDEAD_BEEF}};
      end else start = 1'b0;
      if (cyc > 100) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc <= 100, {req, " R8 watchdog"}, cyc, exp_p);
    chk(cyc == exp_p, {req, " R3 pass count"}, cyc, exp_p);
    chk(!busy, {req, " R8 idle at done"}, busy, 0);
    for (int i = 0; i < L; i++) begin
      logic [31:0] e;
      e = (mask[i] && !we) ? model[wa[i]] : 32'h0;
      if (rd_ok && lane_rdata[i*32 +: 32] !== e) begin
        rd_ok = 1'b0; ra = lane_rdata[i*32 +: 32]; re = e;
      end
    end
    chk(rd_ok, {req, " R4/R7 read data"}, ra, re);
    @(negedge clk);
    chk(!done, {req, " R8 done one cycle"}, done, 0);
    if (we)
      for (int i = 0; i < L; i++) if (mask[i]) model[wa[i]] = data_of(seq, i);
  endtask

  initial begin
    #15;
    chk(!busy && !done, "R1 reset outputs", {busy, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 8; p++) run_req(1'b1, 1'b0, 1, p * 32, '1, 1'b0, "R2 preload");
    for (int v = 0; v < NV; v++)
      run_req(VECS[v].we, VECS[v].wd, int'(VECS[v].mult), int'(VECS[v].off),
              VECS[v].mask, 1'b0, $sformatf("vec%0d R3 R5 R6", v));
    // R6: lanes 0,4,...,28 wrote word 0 in vec 8; word 0 is read back in vec 9
    run_req(1'b0, 1'b0, 1, 0, '1, 1'b0, "R6 winner readback");
    chk(model[0] == data_of(seq - 5, 28), "R6 model winner", model[0], data_of(seq - 5, 28));
    run_req(1'b0, 1'b0, 0, 0, 32'h0101_0101, 1'b0, "R4 masked broadcast");
    run_req(1'b0, 1'b0, 1, 0, '0, 1'b0, "R9 empty request");
    run_req(1'b0, 1'b0, 32, 0, '1, 1'b1, "R8 start while busy");
    run_req(1'b0, 1'b0, 1, 0, '1, 1'b0, "R8 no intruder write");
    run_req(1'b0, 1'b0, 1, 64, '1, 1'b0, "R7 masked write check");
    run_req(1'b0, 1'b1, 1, 128, '1, 1'b0, "R5 wide pairs");
    run_req(1'b0, 1'b0, 2, 128, '1, 1'b0, "R3 narrow stride two");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #4000000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule